// File: doc/BRIEF.md
# First-Error Capture Logger

This block gathers single-cycle error strobes from several sources and stores them as sticky detection bits spread over three banks: two error banks and one bus-status bank. It also drives a machine-check request to the processor. The first error that arrives, or the group of errors that arrive together in one cycle, is logged. Address, command and source information are captured with it. Logging is then locked until software has cleared every detection bit in every bank.

Software clears bits through a plain write-one-to-clear port. The port names a bank and a mask. The strobe inputs are laid out as one flat lane vector of three 16-bit banks: bank 0 in lanes 15..0, bank 1 in lanes 31..16 and bank 2 in lanes 47..32. All pins are plain control and status signals. No port carries a stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `fault_first_logger`

## Requirements
- R1: While reset is asserted and right after it, all detection bits, the captured address, command and source are zero, and `mcp_o` is low.
- R2: Only these lanes can hold a detection bit: bank 0 bits 7..4 and 2..0, bank 1 bits 5..3 and 0, and bank 2 bits 15, 13 and 12. A strobe on any other lane never sets a bit. Bank 0 bit 7 is the system-error lane.
- R3: When every detection bit is clear, the defined strobes present at a clock edge all become set bits after that edge, together.
- R4: While any detection bit is set, new strobes change no detection bit and no capture register.
- R5: When `clr_en_i` is high, each 1 in `clr_mask_i` clears that bit of the bank selected by `clr_bank_i` at the next edge. The bank codes are 0, 1 and 2. Code 3 clears nothing, and other bits and banks are unchanged.
- R6: Logging reopens only when all bits in all three banks are clear. A partial clear keeps it locked.
- R7: On the edge that sets the first bits, `cap_addr_o` and `cap_cmd_o` load `addr_i` and `cmd_i`, and `cap_src_o` loads the lowest set lane index among the accepted strobes. All three hold while any bit stays set.
- R8: `mcp_o` is a level that is high while any set bit lies in bank 0 (any defined bit) or bank 1 bits 5..3. Bank 2 bits never raise it.
- R9: The sideband lane, bank 1 bit 0 (lane 16), raises `mcp_o` only while `mck_en_i` is 1. The gate follows the current value of `mck_en_i` with no register in the path.
- R10: A strobe that arrives in the same cycle as a clear is recorded only if every bit was already clear before that edge. If the lock is closed, the strobe is lost even when the clear empties the banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ev_i | input | 48 | Error strobes, three 16-lane banks |
| addr_i | input | 32 | Address presented with the strobes |
| cmd_i | input | 4 | Command presented with the strobes |
| clr_en_i | input | 1 | Clear write strobe |
| clr_bank_i | input | 2 | Bank selected for the clear |
| clr_mask_i | input | 16 | Write-one-to-clear mask |
| mck_en_i | input | 1 | Enables the sideband lane toward machine check |
| det_o | output | 48 | Detection bits of all banks |
| cap_addr_o | output | 32 | Captured address |
| cap_cmd_o | output | 4 | Captured command |
| cap_src_o | output | 6 | Lowest lane of the captured group |
| mcp_o | output | 1 | Machine-check request level |

## Verification
The assertions check on every cycle that undefined lanes stay clear and that an open logger loads exactly the masked strobes. They also check that a locked logger with no clear holds its bits and its capture registers, and that `mcp_o` is low when nothing is logged. Only the bench's scenarios can show the rest. These are the write-one-to-clear bank decode, the reopening after the very last bit clears, the lowest-lane source encoding, the machine-check lane selection with its sideband enable, and the loss of a strobe that coincides with the final clear.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  localparam int BANKS     = 3;
  localparam int BANK_W    = 16;
  localparam int LANES     = BANKS * BANK_W;

  // Lanes that may hold a detection bit, bank 2 : bank 1 : bank 0.
  localparam logic [LANES-1:0] DEF_DET_MASK = {16'hB000, 16'h0039, 16'h00F7};
  // Lanes that raise machine check unconditionally.
  localparam logic [LANES-1:0] DEF_MCK_MASK = {16'h0000, 16'h0038, 16'h00F7};
  // Sideband lane gated by the enable input.
  localparam int DEF_SIDE_LANE = 16;

  typedef enum logic [1:0] {
    BANK_ERR_A = 2'd0,
    BANK_ERR_B = 2'd1,
    BANK_STAT  = 2'd2,
    BANK_NONE  = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/ffl_bank.sv
module ffl_bank #(
  parameter int              BW   = 16,
  parameter logic [BW-1:0]   MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] ev_i,
  input  logic          clr_i,
  input  logic [BW-1:0] clr_mask_i,
  output logic [BW-1:0] det_o
);
  logic [BW-1:0] det_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      det_q <= '0;
    end else if (load_i) begin
      det_q <= ev_i & MASK;
    end else if (clr_i) begin
      det_q <= det_q & ~clr_mask_i;
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/ffl_capture.sv
module ffl_capture #(
  parameter int AW    = 32,
  parameter int CW    = 4,
  parameter int LANES = 48,
  localparam int SRC_W = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CW-1:0]    cmd_i,
  input  logic [LANES-1:0] lanes_i,
  output logic [AW-1:0]    addr_o,
  output logic [CW-1:0]    cmd_o,
  output logic [SRC_W-1:0] src_o
);
  logic [SRC_W-1:0] first_lane;
  logic [AW-1:0]    addr_q;
  logic [CW-1:0]    cmd_q;
  logic [SRC_W-1:0] src_q;

  // Lowest set lane wins.
  always_comb begin
    first_lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lanes_i[i]) first_lane = SRC_W'(i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cmd_q  <= '0;
      src_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cmd_q  <= cmd_i;
      src_q  <= first_lane;
    end
  end

  assign addr_o = addr_q;
  assign cmd_o  = cmd_q;
  assign src_o  = src_q;
endmodule

// File: rtl/ffl_mck.sv
module ffl_mck #(
  parameter int               LANES     = 48,
  parameter logic [LANES-1:0] MCK_MASK  = '0,
  parameter int               SIDE_LANE = 16
) (
  input  logic [LANES-1:0] det_i,
  input  logic             side_en_i,
  output logic             mcp_o
);
  logic fixed_req;
  logic side_req;

  assign fixed_req = |(det_i & MCK_MASK);
  assign side_req  = det_i[SIDE_LANE] & side_en_i;
  assign mcp_o     = fixed_req | side_req;
endmodule

// File: rtl/fault_first_logger.sv
module fault_first_logger #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int NB = ffl_pkg::BANKS,
  parameter int BW = ffl_pkg::BANK_W,
  parameter logic [NB*BW-1:0] DET_MASK  = ffl_pkg::DEF_DET_MASK,
  parameter logic [NB*BW-1:0] MCK_MASK  = ffl_pkg::DEF_MCK_MASK,
  parameter int               SIDE_LANE = ffl_pkg::DEF_SIDE_LANE,
  localparam int LANES = NB * BW,
  localparam int SEL_W = $clog2(NB + 1),
  localparam int SRC_W = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] ev_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CW-1:0]    cmd_i,
  input  logic             clr_en_i,
  input  logic [SEL_W-1:0] clr_bank_i,
  input  logic [BW-1:0]    clr_mask_i,
  input  logic             mck_en_i,
  output logic [LANES-1:0] det_o,
  output logic [AW-1:0]    cap_addr_o,
  output logic [CW-1:0]    cap_cmd_o,
  output logic [SRC_W-1:0] cap_src_o,
  output logic             mcp_o
);
  logic [LANES-1:0] det;
  logic [LANES-1:0] accepted;
  logic             open;
  logic             load;

  assign accepted = ev_i & DET_MASK;
  assign open     = ~|det;
  assign load     = open & (|accepted);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic clr_sel;
    assign clr_sel = clr_en_i && (clr_bank_i == SEL_W'(b));
    ffl_bank #(
      .BW   (BW),
      .MASK (DET_MASK[b*BW +: BW])
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .ev_i       (ev_i[b*BW +: BW]),
      .clr_i      (clr_sel),
      .clr_mask_i (clr_mask_i),
      .det_o      (det[b*BW +: BW])
    );
  end

  ffl_capture #(
    .AW    (AW),
    .CW    (CW),
    .LANES (LANES)
  ) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .cmd_i   (cmd_i),
    .lanes_i (accepted),
    .addr_o  (cap_addr_o),
    .cmd_o   (cap_cmd_o),
    .src_o   (cap_src_o)
  );

  ffl_mck #(
    .LANES     (LANES),
    .MCK_MASK  (MCK_MASK),
    .SIDE_LANE (SIDE_LANE)
  ) u_mck (
    .det_i     (det),
    .side_en_i (mck_en_i),
    .mcp_o     (mcp_o)
  );

  assign det_o = det;
endmodule

// File: rtl/ffl_checker.sv
module ffl_checker #(
  parameter int LANES = ffl_pkg::LANES,
  parameter logic [LANES-1:0] DET_MASK = ffl_pkg::DEF_DET_MASK
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LANES-1:0] ev_i,
  input logic             clr_en_i,
  input logic [LANES-1:0] det_o,
  input logic [31:0]      cap_addr_o,
  input logic [3:0]       cap_cmd_o,
  input logic [5:0]       cap_src_o,
  input logic             mcp_o
);
  // R2: undefined lanes never hold a bit
  a_r2_defined_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_o & ~DET_MASK) == '0);

  // R3: open logger loads exactly the masked strobes
  a_r3_group_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_o == '0) |=> (det_o == ($past(ev_i) & DET_MASK)));

  // R4: locked logger without clear holds its bits
  a_r4_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|det_o) && !clr_en_i) |=> (det_o == $past(det_o)));

  // R7: capture registers hold while locked
  a_r7_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|det_o) |=> ($stable(cap_addr_o) && $stable(cap_cmd_o) && $stable(cap_src_o)));

  // R8: nothing logged means no machine-check request
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_o == '0) |-> !mcp_o);
endmodule

bind fault_first_logger ffl_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ev_i       (ev_i),
  .clr_en_i   (clr_en_i),
  .det_o      (det_o),
  .cap_addr_o (cap_addr_o),
  .cap_cmd_o  (cap_cmd_o),
  .cap_src_o  (cap_src_o),
  .mcp_o      (mcp_o)
);

// File: tb/tb_fault_first_logger.sv
module tb_fault_first_logger;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [47:0] ev_i = '0;
  logic [31:0] addr_i = '0;
  logic [3:0]  cmd_i = '0;
  logic        clr_en_i = 1'b0;
  logic [1:0]  clr_bank_i = '0;
  logic [15:0] clr_mask_i = '0;
  logic        mck_en_i = 1'b0;
  logic [47:0] det_o;
  logic [31:0] cap_addr_o;
  logic [3:0]  cap_cmd_o;
  logic [5:0]  cap_src_o;
  logic        mcp_o;

  int total = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  fault_first_logger dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev_i), .addr_i(addr_i), .cmd_i(cmd_i),
    .clr_en_i(clr_en_i), .clr_bank_i(clr_bank_i), .clr_mask_i(clr_mask_i),
    .mck_en_i(mck_en_i), .det_o(det_o), .cap_addr_o(cap_addr_o),
    .cap_cmd_o(cap_cmd_o), .cap_src_o(cap_src_o), .mcp_o(mcp_o)
  );

  typedef struct packed {
    logic [47:0] ev;
    logic        clr;
    logic [1:0]  bank;
    logic [15:0] mask;
    logic        mck;
    logic [47:0] det;
    logic        mcp;
  } vec_t;

  // Banks packed as {bank2, bank1, bank0}.
  localparam vec_t TBL [0:13] = '{
    '{48'h0000_0000_0080, 1'b0, 2'd0, 16'h0000, 1'b0, 48'h0000_0000_0080, 1'b1}, // R2 R8 system error
    '{48'h0000_0000_0001, 1'b0, 2'd0, 16'h0000, 1'b0, 48'h0000_0000_0080, 1'b1}, // R4 locked
    '{48'h0000_0000_0000, 1'b1, 2'd0, 16'h0080, 1'b0, 48'h0000_0000_0000, 1'b0}, // R5 clear
    '{48'hFFFF_0000_00FF, 1'b0, 2'd0, 16'h0000, 1'b0, 48'hB000_0000_00F7, 1'b1}, // R3 R2 group
    '{48'h0000_0000_0000, 1'b1, 2'd0, 16'h00F7, 1'b0, 48'hB000_0000_0000, 1'b0}, // R8 bank2 silent
    '{48'h0000_0008_0000, 1'b0, 2'd0, 16'h0000, 1'b0, 48'hB000_0000_0000, 1'b0}, // R6 still locked
    '{48'h0000_0000_0000, 1'b1, 2'd2, 16'h3000, 1'b0, 48'h8000_0000_0000, 1'b0}, // R5 partial
    '{48'h0000_0000_0000, 1'b1, 2'd3, 16'hFFFF, 1'b0, 48'h8000_0000_0000, 1'b0}, // R5 code 3
    '{48'h0000_0008_0000, 1'b1, 2'd2, 16'h8000, 1'b0, 48'h0000_0000_0000, 1'b0}, // R10 lost
    '{48'h0000_0001_0000, 1'b0, 2'd0, 16'h0000, 1'b0, 48'h0000_0001_0000, 1'b0}, // R9 gated off
    '{48'h0000_0000_0000, 1'b0, 2'd0, 16'h0000, 1'b1, 48'h0000_0001_0000, 1'b1}, // R9 gated on
    '{48'h0000_0000_0000, 1'b1, 2'd1, 16'h0001, 1'b1, 48'h0000_0000_0000, 1'b0}, // R6 reopen
    '{48'h0000_0038_0000, 1'b0, 2'd0, 16'h0000, 1'b0, 48'h0000_0038_0000, 1'b1}, // R8 bank1
    '{48'h0000_0000_0000, 1'b1, 2'd1, 16'h0038, 1'b0, 48'h0000_0000_0000, 1'b0}  // R5 empty
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    ev_i = '0; clr_en_i = 1'b0; mck_en_i = 1'b0; addr_i = '0; cmd_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #500000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 det", 64'(det_o), 64'h0);
    chk("R1 mcp", 64'(mcp_o), 64'h0);
    chk("R1 cap", {cap_addr_o, 22'h0, cap_cmd_o, cap_src_o}, 64'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < 14; i++) begin
      @(negedge clk_i);
      ev_i = TBL[i].ev; clr_en_i = TBL[i].clr; clr_bank_i = TBL[i].bank;
      clr_mask_i = TBL[i].mask; mck_en_i = TBL[i].mck;
      @(posedge clk_i); #1;
      chk($sformatf("vector %0d det", i), 64'(det_o), 64'(TBL[i].det));
      chk($sformatf("vector %0d mcp", i), 64'(mcp_o), 64'(TBL[i].mcp));
    end

    // R7: capture of first group, lowest lane wins
    do_reset();
    ev_i = {16'h1000, 16'h0000, 16'h0004}; addr_i = 32'hDEAD_BEEF; cmd_i = 4'h6;
    @(posedge clk_i); #1;
    chk("R7 addr", 64'(cap_addr_o), 64'hDEAD_BEEF);
    chk("R7 cmd", 64'(cap_cmd_o), 64'h6);
    chk("R7 src", 64'(cap_src_o), 64'd2);
    // R4: locked strobe leaves capture alone
    @(negedge clk_i);
    ev_i = {16'h0, 16'h0, 16'h0010}; addr_i = 32'h1234_5678; cmd_i = 4'h3;
    @(posedge clk_i); #1;
    chk("R4 addr held", 64'(cap_addr_o), 64'hDEAD_BEEF);
    chk("R4 src held", 64'(cap_src_o), 64'd2);
    chk("R4 det held", 64'(det_o), 64'h1000_0000_0004);
    @(negedge clk_i);
    ev_i = '0; clr_en_i = 1'b1; clr_bank_i = 2'd0; clr_mask_i = 16'h0004;
    @(negedge clk_i);
    clr_bank_i = 2'd2; clr_mask_i = 16'h1000;
    @(posedge clk_i); #1;
    chk("R6 all clear", 64'(det_o), 64'h0);
    // R10: open logger records strobe despite coinciding clear
    @(negedge clk_i);
    clr_bank_i = 2'd1; clr_mask_i = 16'h0008;
    ev_i = {16'h0, 16'h0008, 16'h0}; addr_i = 32'hCAFE_0000; cmd_i = 4'h9;
    @(posedge clk_i); #1;
    chk("R10 open set", 64'(det_o), 64'h0000_0008_0000);
    chk("R7 src lane 19", 64'(cap_src_o), 64'd19);
    chk("R7 addr new", 64'(cap_addr_o), 64'hCAFE_0000);
    @(negedge clk_i);
    ev_i = '0; clr_en_i = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule